// File: doc/BRIEF.md
# ATA Command Word Interpreter

This block sits between a queue of 16-bit command words and a PIO cycle engine that drives an ATA bus. Each word carries its own opcode together with its operands: chip-select and register address with a data byte for register accesses, a transfer count for data bursts, or a device/count-unit selection. The interpreter pops one word, turns it into one or more requests to the cycle engine, and pops the next word only after the current command has completed.

Write data for bursts comes from a write data queue. Register-read results and burst read data both go into a read data queue. All three queues use ready/valid handshakes. The block tracks the selected device and whether burst counts are in single 16-bit units or in 8-byte blocks. For data bursts it runs a countdown of remaining cycles, and it flags illegal words and aborted operations. Cycle timing, DMA and the decoding of host-side registers belong to other blocks.

Top module: `ata_cmd_interp`

## Requirements
- R1: After reset the block is idle. It is ready for a command, with no cycle request, no read-queue push, device 0, unit counting, a remaining count of zero and both error flags clear.
- R2: A word with bits 15:13 = 001 issues one read cycle. The cycle uses chip-select from bits 12:11 and address from bits 10:8. The returned low byte, zero-extended to 16 bits, is pushed into the read queue. The cycle request holds its chip-select and address stable until the engine reports completion.
- R3: A word with bits 15:13 = 101 issues one write cycle with the same chip-select and address fields. The cycle data is bits 7:0, zero-extended.
- R4: A word with bits 14:13 = 10 starts a data burst to the data register: chip-select 2'b10, address 0. Bit 15 = 1 selects write and 0 selects read. In unit mode the remaining count loads bits 12:0 plus one.
- R5: In block mode, a data burst loads (bits 12:0 plus one) times four, because each 8-byte block is four 16-bit cycles.
- R6: A word whose bits 15:2 equal 14'h2740 sets the selected device from bit 0 (1 = slave) and the count mode from bit 1 (1 = block). It issues no cycle, and the block stays idle.
- R7: A word matching no opcode is discarded without a cycle and sets the illegal-command flag. The flag stays set until reset, and the next word is still accepted.
- R8: The remaining count drops by exactly one for each completed burst cycle, and the burst ends when the count reaches zero.
- R9: A write burst pops one word from the write queue before each cycle and drives that word as the cycle data. While the write queue is empty, no cycle is requested.
- R10: During a read burst, each result is held in the read queue with stable data until it is accepted. No further cycle starts while the result is waiting.
- R11: No command word is accepted while an operation is in progress.
- R12: A terminate request during an operation returns the block to idle on the next cycle. It clears the remaining count and sets a terminated flag that stays set until reset. A terminate request while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 16 | Command word |
| cmd_ready | output | 1 | Command word accepted this cycle when valid |
| term_req | input | 1 | Abort the current operation |
| cyc_req | output | 1 | Request one PIO cycle, held until done |
| cyc_write | output | 1 | Requested cycle is a write |
| cyc_cs | output | 2 | Chip-select for the cycle |
| cyc_addr | output | 3 | Register address for the cycle |
| cyc_wdata | output | 16 | Write data for the cycle |
| cyc_done | input | 1 | Cycle engine completed the requested cycle |
| cyc_rdata | input | 16 | Read data returned with cyc_done |
| wq_valid | input | 1 | Write queue holds a word |
| wq_data | input | 16 | Write queue head word |
| wq_ready | output | 1 | Pop the write queue head |
| rq_valid | output | 1 | Read queue push request |
| rq_data | output | 16 | Word to push into the read queue |
| rq_ready | input | 1 | Read queue can take a word |
| pio_busy | output | 1 | An operation is in progress |
| dev_sel | output | 1 | Selected device (1 = slave) |
| blk_mode | output | 1 | Burst counts are in 8-byte blocks |
| xfer_left | output | 16 | Remaining burst cycles |
| term_err | output | 1 | An operation was terminated |
| illegal_cmd | output | 1 | An illegal command word was seen |

## Verification
Two things can happen in the same cycle: a terminate request and the engine's completion of a burst read cycle. Without a rule, the completion would decrement the count and queue a read result while the terminate tries to abandon the operation. The bench waits until it sees cyc_done high away from the clock edge and raises term_req for exactly that edge. It then judges the result from the ports: the block must be idle with a zero count, the terminated flag must be set, and no read-queue push may follow. A second overlap is a blocked queue handshake together with a terminate, which is provoked by stalling the read queue and the write queue in turn.

// File: rtl/ata_cmd_pkg.sv
package ata_cmd_pkg;

  localparam int CMD_W   = 16;
  localparam int CNTF_W  = 13;
  localparam logic [13:0] SETDEV_KEY = 14'h2740;

  typedef enum logic [2:0] {
    CK_REG_RD,
    CK_REG_WR,
    CK_DATA,
    CK_SET_DEV,
    CK_BAD
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REG,
    ST_REG_PUSH,
    ST_DATA_WAIT,
    ST_DATA_CYC,
    ST_DATA_PUSH
  } fsm_state_e;

  typedef struct packed {
    cmd_kind_e          kind;
    logic               to_dev;
    logic [1:0]         cs;
    logic [2:0]         addr;
    logic [7:0]         wbyte;
    logic [CNTF_W-1:0]  nminus1;
    logic               sel_dev;
    logic               sel_blk;
  } cmd_fields_t;

endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
  import ata_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_fields_t      fields
);

  always_comb begin
    fields         = '0;
    fields.cs      = word[12:11];
    fields.addr    = word[10:8];
    fields.wbyte   = word[7:0];
    fields.nminus1 = word[CNTF_W-1:0];
    fields.to_dev  = word[15];
    fields.sel_dev = word[0];
    fields.sel_blk = word[1];
    if (word[15:13] == 3'b001) begin
      fields.kind = CK_REG_RD;
    end else if (word[15:13] == 3'b101) begin
      fields.kind = CK_REG_WR;
    end else if (word[14:13] == 2'b10) begin
      fields.kind = CK_DATA;
    end else if (word[15:2] == SETDEV_KEY) begin
      fields.kind = CK_SET_DEV;
    end else begin
      fields.kind = CK_BAD;
    end
  end

endmodule

// File: rtl/ata_xfer_counter.sv
module ata_xfer_counter #(
  parameter int N_W       = 13,
  parameter int BLK_SHIFT = 2,
  localparam int CNT_W    = N_W + BLK_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_W-1:0]   nminus1,
  input  logic             blk,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             last,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] base, load_val;

  assign base     = {{(CNT_W-N_W){1'b0}}, nminus1} + CNT_W'(1);
  assign load_val = blk ? (base << BLK_SHIFT) : base;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign last  = (cnt_q == CNT_W'(1));
  assign zero  = (cnt_q == '0);

endmodule

// File: rtl/ata_dev_settings.sv
module ata_dev_settings (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic sel_dev,
  input  logic sel_blk,
  input  logic bad_en,
  input  logic term_en,
  output logic dev_sel,
  output logic blk_mode,
  output logic illegal_cmd,
  output logic term_err
);

  logic dev_q, dev_d, blk_q, blk_d, ill_q, ill_d, trm_q, trm_d;

  always_comb begin
    dev_d = dev_q;
    blk_d = blk_q;
    if (set_en) begin
      dev_d = sel_dev;
      blk_d = sel_blk;
    end
    ill_d = ill_q | bad_en;
    trm_d = trm_q | term_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= 1'b0;
      blk_q <= 1'b0;
      ill_q <= 1'b0;
      trm_q <= 1'b0;
    end else begin
      dev_q <= dev_d;
      blk_q <= blk_d;
      ill_q <= ill_d;
      trm_q <= trm_d;
    end
  end

  assign dev_sel     = dev_q;
  assign blk_mode    = blk_q;
  assign illegal_cmd = ill_q;
  assign term_err    = trm_q;

endmodule

// File: rtl/ata_cmd_interp.sv
module ata_cmd_interp
  import ata_cmd_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter logic [1:0]  DATA_CS   = 2'b10,
  parameter logic [2:0]  DATA_ADDR = 3'd0,
  parameter int          BLK_SHIFT = 2,
  localparam int         CNT_W     = CNTF_W + BLK_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_ready,
  input  logic              term_req,
  output logic              cyc_req,
  output logic              cyc_write,
  output logic [1:0]        cyc_cs,
  output logic [2:0]        cyc_addr,
  output logic [DATA_W-1:0] cyc_wdata,
  input  logic              cyc_done,
  input  logic [DATA_W-1:0] cyc_rdata,
  input  logic              wq_valid,
  input  logic [DATA_W-1:0] wq_data,
  output logic              wq_ready,
  output logic              rq_valid,
  output logic [DATA_W-1:0] rq_data,
  input  logic              rq_ready,
  output logic              pio_busy,
  output logic              dev_sel,
  output logic              blk_mode,
  output logic [CNT_W-1:0]  xfer_left,
  output logic              term_err,
  output logic              illegal_cmd
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  cmd_fields_t f;
  ata_cmd_decode u_dec (.word(cmd_word), .fields(f));

  fsm_state_e state_q, state_d;
  logic ld_cmd, cnt_load, cnt_dec, cnt_clr;
  logic set_en, bad_en, term_en;
  logic cap_wq, cap_rd, cap_reg_rd;
  logic cnt_last, cnt_zero;
  logic accept, busy_now;

  logic              op_write_q;
  logic [1:0]        cs_q;
  logic [2:0]        addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  assign busy_now = (state_q != ST_IDLE);
  assign accept   = cmd_valid && (state_q == ST_IDLE);

  // next-state logic
  always_comb begin
    state_d    = state_q;
    ld_cmd     = 1'b0;
    cnt_load   = 1'b0;
    cnt_dec    = 1'b0;
    cnt_clr    = 1'b0;
    set_en     = 1'b0;
    bad_en     = 1'b0;
    term_en    = 1'b0;
    cap_wq     = 1'b0;
    cap_rd     = 1'b0;
    cap_reg_rd = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (f.kind)
            CK_REG_RD, CK_REG_WR: begin
              ld_cmd  = 1'b1;
              state_d = ST_REG;
            end
            CK_DATA: begin
              ld_cmd   = 1'b1;
              cnt_load = 1'b1;
              state_d  = f.to_dev ? ST_DATA_WAIT : ST_DATA_CYC;
            end
            CK_SET_DEV: set_en = 1'b1;
            default:    bad_en = 1'b1;
          endcase
        end
      end
      ST_REG: begin
        if (cyc_done) begin
          if (op_write_q) begin
            state_d = ST_IDLE;
          end else begin
            cap_reg_rd = 1'b1;
            state_d    = ST_REG_PUSH;
          end
        end
      end
      ST_REG_PUSH: begin
        if (rq_ready) state_d = ST_IDLE;
      end
      ST_DATA_WAIT: begin
        if (wq_valid) begin
          cap_wq  = 1'b1;
          state_d = ST_DATA_CYC;
        end
      end
      ST_DATA_CYC: begin
        if (cyc_done) begin
          cnt_dec = 1'b1;
          if (!op_write_q) begin
            cap_rd  = 1'b1;
            state_d = ST_DATA_PUSH;
          end else begin
            state_d = cnt_last ? ST_IDLE : ST_DATA_WAIT;
          end
        end
      end
      ST_DATA_PUSH: begin
        if (rq_ready) state_d = cnt_zero ? ST_IDLE : ST_DATA_CYC;
      end
      default: state_d = ST_IDLE;
    endcase
    // terminate overrides every other action of the cycle
    if (term_req && busy_now) begin
      state_d    = ST_IDLE;
      cnt_clr    = 1'b1;
      cnt_dec    = 1'b0;
      term_en    = 1'b1;
      cap_wq     = 1'b0;
      cap_rd     = 1'b0;
      cap_reg_rd = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // operand and data registers, each with its own enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_write_q <= 1'b0;
      cs_q       <= 2'b00;
      addr_q     <= 3'd0;
      wdata_q    <= '0;
      rdata_q    <= '0;
    end else begin
      if (ld_cmd) begin
        op_write_q <= (f.kind == CK_REG_WR) || ((f.kind == CK_DATA) && f.to_dev);
        cs_q       <= (f.kind == CK_DATA) ? DATA_CS : f.cs;
        addr_q     <= (f.kind == CK_DATA) ? DATA_ADDR : f.addr;
        wdata_q    <= {{(DATA_W-8){1'b0}}, f.wbyte};
      end else if (cap_wq) begin
        wdata_q <= wq_data;
      end
      if (cap_reg_rd) begin
        rdata_q <= {{(DATA_W-8){1'b0}}, cyc_rdata[7:0]};
      end else if (cap_rd) begin
        rdata_q <= cyc_rdata;
      end
    end
  end

  ata_xfer_counter #(.N_W(CNTF_W), .BLK_SHIFT(BLK_SHIFT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (cnt_load),
    .nminus1 (f.nminus1),
    .blk     (blk_mode),
    .dec     (cnt_dec),
    .clr     (cnt_clr),
    .count   (xfer_left),
    .last    (cnt_last),
    .zero    (cnt_zero)
  );

  ata_dev_settings u_set (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .set_en      (set_en),
    .sel_dev     (f.sel_dev),
    .sel_blk     (f.sel_blk),
    .bad_en      (bad_en),
    .term_en     (term_en),
    .dev_sel     (dev_sel),
    .blk_mode    (blk_mode),
    .illegal_cmd (illegal_cmd),
    .term_err    (term_err)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign pio_busy  = busy_now;
  assign cyc_req   = (state_q == ST_REG) || (state_q == ST_DATA_CYC);
  assign cyc_write = op_write_q;
  assign cyc_cs    = cs_q;
  assign cyc_addr  = addr_q;
  assign cyc_wdata = wdata_q;
  assign wq_ready  = (state_q == ST_DATA_WAIT) && !term_req;
  assign rq_valid  = (state_q == ST_REG_PUSH) || (state_q == ST_DATA_PUSH);
  assign rq_data   = rdata_q;

endmodule

// File: rtl/ata_cmd_interp_chk.sv
module ata_cmd_interp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [15:0]      cmd_word,
  input logic             cmd_ready,
  input logic             term_req,
  input logic             cyc_req,
  input logic [1:0]       cyc_cs,
  input logic [2:0]       cyc_addr,
  input logic             cyc_done,
  input logic             wq_ready,
  input logic             rq_valid,
  input logic [15:0]      rq_data,
  input logic             rq_ready,
  input logic             pio_busy,
  input logic             dev_sel,
  input logic [CNT_W-1:0] xfer_left,
  input logic             term_err,
  input logic             illegal_cmd
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && !cyc_done && !term_req |=> cyc_req && $stable(cyc_cs) && $stable(cyc_addr));

  p_setdev_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_word[15:2] == 14'h2740) |=> !pio_busy && (dev_sel == $past(cmd_word[0])));

  p_illegal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |=> illegal_cmd);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && cyc_done && !term_req && (xfer_left != '0) |=> xfer_left == $past(xfer_left) - CNT_W'(1));

  p_no_cycle_on_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wq_ready |-> !cyc_req);

  p_rq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready && !term_req |=> rq_valid && $stable(rq_data));

  p_no_pop_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pio_busy |-> !cmd_ready);

  p_term_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    term_req && pio_busy |=> !pio_busy && term_err && (xfer_left == '0));

endmodule

bind ata_cmd_interp ata_cmd_interp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_valid   (cmd_valid),
  .cmd_word    (cmd_word),
  .cmd_ready   (cmd_ready),
  .term_req    (term_req),
  .cyc_req     (cyc_req),
  .cyc_cs      (cyc_cs),
  .cyc_addr    (cyc_addr),
  .cyc_done    (cyc_done),
  .wq_ready    (wq_ready),
  .rq_valid    (rq_valid),
  .rq_data     (rq_data),
  .rq_ready    (rq_ready),
  .pio_busy    (pio_busy),
  .dev_sel     (dev_sel),
  .xfer_left   (xfer_left),
  .term_err    (term_err),
  .illegal_cmd (illegal_cmd)
);

// File: tb/ata_cmd_interp_test.sv
`timescale 1ns/1ps
module ata_cmd_interp_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic        cmd_ready;
  logic        term_req;
  logic        cyc_req, cyc_write;
  logic [1:0]  cyc_cs;
  logic [2:0]  cyc_addr;
  logic [15:0] cyc_wdata;
  logic        cyc_done;
  logic [15:0] cyc_rdata;
  logic        wq_valid;
  logic [15:0] wq_data;
  logic        wq_ready;
  logic        rq_valid;
  logic [15:0] rq_data;
  logic        rq_ready;
  logic        pio_busy, dev_sel, blk_mode, term_err, illegal_cmd;
  logic [15:0] xfer_left;

  always #2.5 clk = ~clk;

  ata_cmd_interp uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .term_req(term_req), .cyc_req(cyc_req),
    .cyc_write(cyc_write), .cyc_cs(cyc_cs), .cyc_addr(cyc_addr),
    .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .cyc_rdata(cyc_rdata),
    .wq_valid(wq_valid), .wq_data(wq_data), .wq_ready(wq_ready),
    .rq_valid(rq_valid), .rq_data(rq_data), .rq_ready(rq_ready),
    .pio_busy(pio_busy), .dev_sel(dev_sel), .blk_mode(blk_mode),
    .xfer_left(xfer_left), .term_err(term_err), .illegal_cmd(illegal_cmd)
  );

  localparam logic [15:0] ENGINE_RD = 16'hB3C7;

  // cycle engine model, queue models and activity monitor
  int          dly;
  int          cyc_cnt, rd_cnt, wd_chk, wd_bad;
  logic        last_w;
  logic [1:0]  last_cs;
  logic [2:0]  last_addr;
  logic [15:0] last_wd, last_rd, last_pop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_done <= 1'b0; dly <= 0; cyc_cnt <= 0; rd_cnt <= 0;
      wd_chk <= 0; wd_bad <= 0; wq_data <= 16'h7000; last_pop <= 16'h0;
      last_w <= 1'b0; last_cs <= 2'b0; last_addr <= 3'b0;
      last_wd <= 16'h0; last_rd <= 16'h0;
    end else begin
      if (cyc_req && !cyc_done) begin
        if (dly == 2) begin cyc_done <= 1'b1; dly <= 0; end
        else dly <= dly + 1;
      end else begin
        cyc_done <= 1'b0;
        if (!cyc_req) dly <= 0;
      end
      if (cyc_req && cyc_done) begin
        cyc_cnt   <= cyc_cnt + 1;
        last_w    <= cyc_write;
        last_cs   <= cyc_cs;
        last_addr <= cyc_addr;
        last_wd   <= cyc_wdata;
        if (cyc_write && cyc_cs == 2'b10 && cyc_addr == 3'd0) begin
          wd_chk <= wd_chk + 1;   // R9: burst write data is the popped word
          if (cyc_wdata !== last_pop) begin
            wd_bad <= wd_bad + 1;
            $display("FAIL R9 burst write data: actual %h expected %h", cyc_wdata, last_pop);
          end
        end
      end
      if (rq_valid && rq_ready) begin
        rd_cnt  <= rd_cnt + 1;
        last_rd <= rq_data;
      end
      if (wq_valid && wq_ready) begin
        last_pop <= wq_data;
        wq_data  <= wq_data + 16'h1;
      end
    end
  end
  assign cyc_rdata = ENGINE_RD;

  typedef struct packed {
    logic [15:0] cmd;
    logic [7:0]  ncyc;
    logic        w;
    logic [1:0]  cs;
    logic [2:0]  addr;
    logic        chkd;
    logic [15:0] wdat;
    logic [7:0]  nrd;
    logic [15:0] rdat;
    logic        dev;
    logic        blk;
    logic        ill;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{16'h2F00, 8'd1, 1'b0, 2'd1, 3'd7, 1'b0, 16'h0000, 8'd1, 16'h00C7, 1'b0, 1'b0, 1'b0},
    '{16'hB35A, 8'd1, 1'b1, 2'd2, 3'd3, 1'b1, 16'h005A, 8'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
    '{16'h4002, 8'd3, 1'b0, 2'd2, 3'd0, 1'b0, 16'h0000, 8'd3, 16'hB3C7, 1'b0, 1'b0, 1'b0},
    '{16'hC001, 8'd2, 1'b1, 2'd2, 3'd0, 1'b0, 16'h0000, 8'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
    '{16'h9D03, 8'd0, 1'b0, 2'd0, 3'd0, 1'b0, 16'h0000, 8'd0, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{16'hC000, 8'd4, 1'b1, 2'd2, 3'd0, 1'b0, 16'h0000, 8'd0, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{16'h4001, 8'd8, 1'b0, 2'd2, 3'd0, 1'b0, 16'h0000, 8'd8, 16'hB3C7, 1'b1, 1'b1, 1'b0},
    '{16'h9D00, 8'd0, 1'b0, 2'd0, 3'd0, 1'b0, 16'h0000, 8'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
    '{16'h0000, 8'd0, 1'b0, 2'd0, 3'd0, 1'b0, 16'h0000, 8'd0, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{16'hC000, 8'd1, 1'b1, 2'd2, 3'd0, 1'b0, 16'h0000, 8'd0, 16'h0000, 1'b0, 1'b0, 1'b1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R9";
      4: return "R6";
      5: return "R5";
      6: return "R8";
      7: return "R6";
      8: return "R7";
      default: return "R4";
    endcase
  endfunction

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    for (int k = 0; k < 2000 && !cmd_ready; k++) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && pio_busy; k++) @(negedge clk);
  endtask

  task automatic pulse_term();
    @(negedge clk);
    term_req = 1'b1;
    @(negedge clk);
    term_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + 1, n_bad + wd_bad + 1);
    $finish;
  end

  initial begin
    int c0, r0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = 16'h0; term_req = 1'b0;
    wq_valid = 1'b1; rq_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1", "ready/busy/req/push", {28'h0, cmd_ready, pio_busy, cyc_req, rq_valid}, 32'h8);
    check("R1", "dev/blk/term/illegal", {28'h0, dev_sel, blk_mode, term_err, illegal_cmd}, 32'h0);
    check("R1", "remaining count", {16'h0, xfer_left}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      c0 = cyc_cnt; r0 = rd_cnt;
      send_cmd(VT[i].cmd);
      wait_idle();
      @(negedge clk);
      check(tag_of(i), "cycle count", cyc_cnt - c0, {24'h0, VT[i].ncyc});
      if (VT[i].ncyc != 8'd0)
        check(tag_of(i), "last cycle w/cs/addr", {26'h0, last_w, last_cs, last_addr},
              {26'h0, VT[i].w, VT[i].cs, VT[i].addr});
      if (VT[i].chkd)
        check(tag_of(i), "register write data", {16'h0, last_wd}, {16'h0, VT[i].wdat});
      check(tag_of(i), "read pushes", rd_cnt - r0, {24'h0, VT[i].nrd});
      if (VT[i].nrd != 8'd0)
        check(tag_of(i), "read value", {16'h0, last_rd}, {16'h0, VT[i].rdat});
      check(tag_of(i), "dev/blk/illegal", {29'h0, dev_sel, blk_mode, illegal_cmd},
            {29'h0, VT[i].dev, VT[i].blk, VT[i].ill});
      check("R8", "idle with count zero", {15'h0, pio_busy, xfer_left}, 32'h0);
    end

    // R12: terminate while idle is ignored
    pulse_term();
    check("R12", "idle terminate: busy/term_err", {30'h0, pio_busy, term_err}, 32'h0);

    // R10 / R8: read burst stalled by a full read queue, then aborted
    rq_ready = 1'b0;
    send_cmd(16'h5FFF);
    check("R4", "unit-mode load of max count", {16'h0, xfer_left}, 32'd8192);
    repeat (10) @(negedge clk);
    check("R8", "count after one completed cycle", {16'h0, xfer_left}, 32'd8191);
    check("R10", "result held valid", {30'h0, rq_valid, cyc_req}, 32'h2);
    check("R10", "held result data", {16'h0, rq_data}, {16'h0, ENGINE_RD});
    repeat (5) @(negedge clk);
    check("R10", "still held, no new cycle", {15'h0, rq_valid, xfer_left}, {15'h0, 1'b1, 16'd8191});
    pulse_term();
    check("R12", "abort: busy/push/term_err", {29'h0, pio_busy, rq_valid, term_err}, 32'h1);
    check("R12", "abort clears count", {16'h0, xfer_left}, 32'h0);
    rq_ready = 1'b1;

    // R5 / R9 / R11: write burst stalled by an empty write queue
    send_cmd(16'h9D03);
    wq_valid = 1'b0;
    c0 = cyc_cnt;
    send_cmd(16'hC002);
    check("R5", "block-mode load", {16'h0, xfer_left}, 32'd12);
    repeat (6) @(negedge clk);
    check("R9", "no cycle while write queue empty", {30'h0, cyc_req, pio_busy}, 32'h1);
    check("R9", "no cycles completed", cyc_cnt - c0, 32'h0);
    check("R11", "no command accepted while busy", {31'h0, cmd_ready}, 32'h0);
    pulse_term();
    check("R12", "abort of stalled write", {15'h0, pio_busy, xfer_left}, 32'h0);
    wq_valid = 1'b1;
    send_cmd(16'h9D00);

    // R12: terminate in the same cycle as a burst read completion
    send_cmd(16'h4001);
    for (int k = 0; k < 100 && !cyc_done; k++) @(negedge clk);
    r0 = rd_cnt;
    term_req = 1'b1;
    @(negedge clk);
    term_req = 1'b0;
    check("R12", "terminate wins over completion", {15'h0, pio_busy, xfer_left}, 32'h0);
    repeat (3) @(negedge clk);
    check("R12", "no read pushed after terminate", rd_cnt - r0, 32'h0);
    check("R12", "term_err sticky", {31'h0, term_err}, 32'h1);

    n_vec += wd_chk;
    n_bad += wd_bad;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule